// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block turns an asynchronous serial line into bytes. The line is synchronised into the clock domain and then watched on every pulse of a 16x oversampling strobe. A falling edge starts a frame. The receiver then collects 5 to 8 data bits, least significant bit first. It can check a parity bit and one or two stop bits. Each completed frame is written into a small receive FIFO. The strobe itself comes from a baud generator outside this block.

Parity, framing and overrun problems set status flags that stay set. They are cleared only while a level-sensitive clear input is held high. The flags do not clear themselves, so software raises the clear input and then lowers it again. A line held low (a break) shows up as a single 0x00 byte together with a frame error. The receiver does not start another frame until the line has gone high again.

Software reads bytes through a pop strobe and can see the FIFO-empty status at any time. An interrupt output is raised when the FIFO holds at least a programmable number of bytes. A flush input empties the FIFO, and an enable input gates reception.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, `rx_empty` is 1, `parity_err`, `frame_err`, `overrun_err` and `irq` are 0.
- R2: A frame is a low start bit, then the data bits LSB first, then an optional parity bit, then the stop bit(s), each lasting 16 strobes. Received bytes leave the FIFO in arrival order on `rd_data[7:0]`.
- R3: `data_len` selects the number of data bits: 0 gives 8, 1 gives 7, 2 gives 6 and 3 gives 5. The unused upper bits of the stored byte are 0.
- R4: When `parity_on` is 1, a parity bit follows the data. With `parity_odd`=0, the data plus the parity bit must hold an even number of ones; with `parity_odd`=1, an odd number. A mismatch sets `parity_err`, and the byte is still stored.
- R5: A stop bit sampled as 0 sets `frame_err`. When `two_stop` is 1, both stop bits are sampled, and either one being 0 sets the flag.
- R6: A line held low produces exactly one 0x00 byte with `frame_err` set. No further frame starts until the line has returned high.
- R7: A low pulse that is no longer low at the mid-bit sample (the 8th strobe after the falling edge) is discarded, and nothing is stored.
- R8: `parity_err`, `frame_err` and `overrun_err` stay set until `err_clear` is sampled high. While `err_clear` is high, all three read 0 on the next cycle.
- R9: A frame that completes while the FIFO (depth 16) is full is dropped and sets `overrun_err`. The bytes already stored are unchanged.
- R10: `rx_empty` is 1 exactly when the FIFO holds no byte. A `rd_en` pulse removes the byte shown on `rd_data`.
- R11: `irq` is 1 when `irq_enable` is 1, the FIFO is not empty, and its level is at least `irq_level`.
- R12: While `rx_flush` is high, the FIFO is emptied on the next cycle. While `rx_enable` is low, no frame is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick_16x | input | 1 | Oversampling strobe, 16 per bit |
| rx_enable | input | 1 | Reception enable |
| rx_flush | input | 1 | Level flush of the receive FIFO |
| err_clear | input | 1 | Level clear of the sticky error flags |
| data_len | input | 2 | Data bit count code (0:8, 1:7, 2:6, 3:5) |
| parity_on | input | 1 | Parity bit present |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| irq_level | input | 8 | FIFO level that raises the interrupt |
| irq_enable | input | 1 | Interrupt enable |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rx_empty | output | 1 | FIFO holds no data |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky frame error |
| overrun_err | output | 1 | Sticky overrun error |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions check on every cycle the behaviour that is visible from the status signals. They cover the stickiness and the clear-on-level behaviour of the three error flags, the relation between the empty flag and the FIFO level, the interrupt conditions, the effect of the flush input, and the fact that the FIFO level cannot grow while reception is disabled. Only the bench scenarios can show what depends on the serial waveform. That covers bit order, data length, parity polarity, stop-bit checking, the single zero byte on a break, the rejection of a short start pulse, and overrun dropping only the newest byte. The bench checks these through a scoreboard of expected bytes and through the flags sampled after each frame.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampled serial receiver.
// Holds the frame configuration record and the framer state encoding.
package uart_rx_pkg;

    localparam int BYTE_W = 8;

    // Frame format as seen by the framer; must be stable during a frame.
    typedef struct packed {
        logic [1:0] len_code;   // 0:8, 1:7, 2:6, 3:5 data bits
        logic       par_on;
        logic       par_odd;
        logic       two_stop;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial input into the clock domain through a
// chain of flip-flops. Assumes the line idles high, so reset loads ones.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], line_async};
        end
    end

    assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
// Module: rx_framer
// Finds start bits, samples data, parity and stop bits at mid-bit, and
// emits one completed frame per push pulse. Assumes 'tick' pulses OVS
// times per bit and the configuration stays constant within a frame.
// A new frame needs a high-to-low transition seen on two ticks.
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              enable,
    input  rx_cfg_t           cfg,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS / 2 - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [BYTE_W-1:0] shreg;
    logic              line_q;
    logic              perr_q;
    logic              ferr_q;
    logic              exp_par;

    // Index of the final data bit for the configured length.
    assign last_idx = IDX_W'(BYTE_W - 1) - IDX_W'(cfg.len_code);

    // Parity bit value that the received data calls for.
    assign exp_par = (^shreg) ^ cfg.par_odd;

    // Frame sequencer: walks start, data, parity and stop phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            line_q    <= 1'b1;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
        end else begin
            push <= 1'b0;
            if (!enable) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                line_q <= 1'b1;
            end else if (tick) begin
                line_q <= line;
                case (state)
                    ST_IDLE: begin
                        if (line_q && !line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_CNT) begin
                            cnt <= '0;
                            if (!line) begin
                                state  <= ST_DATA;
                                idx    <= '0;
                                shreg  <= '0;
                                perr_q <= 1'b0;
                                ferr_q <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL_CNT) begin
                            cnt        <= '0;
                            shreg[idx] <= line;
                            if (idx == last_idx) begin
                                state <= cfg.par_on ? ST_PAR : ST_STOP1;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL_CNT) begin
                            cnt    <= '0;
                            perr_q <= (line != exp_par);
                            state  <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (cnt == FULL_CNT) begin
                            cnt <= '0;
                            if (cfg.two_stop) begin
                                ferr_q <= !line;
                                state  <= ST_STOP2;
                            end else begin
                                push      <= 1'b1;
                                push_data <= shreg;
                                push_perr <= perr_q;
                                push_ferr <= !line;
                                state     <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (cnt == FULL_CNT) begin
                            cnt       <= '0;
                            push      <= 1'b1;
                            push_data <= shreg;
                            push_perr <= perr_q;
                            push_ferr <= ferr_q | !line;
                            state     <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_fifo.sv
// Module: rx_fifo
// Show-ahead byte FIFO: rd_data always presents the oldest entry.
// Pushes into a full FIFO and pops from an empty one are ignored.
// A flush empties it on the next edge and also blocks that cycle's push.
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [LVL_W-1:0] wr_ptr;
    logic [LVL_W-1:0] rd_ptr;
    logic             do_wr;
    logic             do_rd;

    // Status from the pointer pair: equal pointers mean empty.
    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) &&
                   (wr_ptr[AW] != rd_ptr[AW]);
    assign level = wr_ptr - rd_ptr;

    assign do_wr = wr && !full && !flush;
    assign do_rd = rd && !empty && !flush;

    assign rd_data = mem[rd_ptr[AW-1:0]];

    // Storage write port; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    // Pointer update with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_sticky.sv
// Module: uart_rx_sticky
// Top level of the oversampled serial receiver. Connects the synchroniser,
// the framer and the receive FIFO. Holds the sticky parity, frame and
// overrun flags and drives the level-threshold interrupt. Assumes
// tick_16x comes from an external baud generator.
module uart_rx_sticky
    import uart_rx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int OVS      = 16,
    parameter int LEVEL_W  = 8,
    parameter int SYNC_STG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_line,
    input  logic               tick_16x,
    input  logic               rx_enable,
    input  logic               rx_flush,
    input  logic               err_clear,
    input  logic [1:0]         data_len,
    input  logic               parity_on,
    input  logic               parity_odd,
    input  logic               two_stop,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic               irq_enable,
    input  logic               rd_en,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rx_empty,
    output logic               parity_err,
    output logic               frame_err,
    output logic               overrun_err,
    output logic               irq
);

    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic              line_s;
    rx_cfg_t           cfg;
    logic              f_push;
    logic [BYTE_W-1:0] f_data;
    logic              f_perr;
    logic              f_ferr;
    logic              fifo_full;
    logic [LVL_W-1:0]  fifo_level;

    assign cfg = '{len_code: data_len, par_on: parity_on,
                   par_odd: parity_odd, two_stop: two_stop};

    rx_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (rx_line),
        .line_sync  (line_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .line      (line_s),
        .enable    (rx_enable),
        .cfg       (cfg),
        .push      (f_push),
        .push_data (f_data),
        .push_perr (f_perr),
        .push_ferr (f_ferr)
    );

    rx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .wr      (f_push),
        .wr_data (f_data),
        .rd      (rd_en),
        .rd_data (rd_data),
        .empty   (rx_empty),
        .full    (fifo_full),
        .level   (fifo_level)
    );

    // Sticky error flags: set by frame events, cleared while err_clear is high.
    always_ff @(posedge clk) begin
        if (!rst_n || err_clear) begin
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else if (f_push) begin
            if (f_perr)                 parity_err  <= 1'b1;
            if (f_ferr)                 frame_err   <= 1'b1;
            if (fifo_full && !rx_flush) overrun_err <= 1'b1;
        end
    end

    // Level-threshold interrupt from the FIFO fill level.
    always_comb begin
        irq = irq_enable && !rx_empty &&
              (LEVEL_W'(fifo_level) >= irq_level);
    end

endmodule

// File: rtl/uart_rx_sticky_chk.sv
// Module: uart_rx_sticky_chk
// Checker for uart_rx_sticky, attached through bind. It watches the flags,
// the interrupt, the flush and enable behaviour and the FIFO level.
module uart_rx_sticky_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_enable,
    input logic             rx_flush,
    input logic             err_clear,
    input logic             irq_enable,
    input logic             rx_empty,
    input logic             parity_err,
    input logic             frame_err,
    input logic             overrun_err,
    input logic             irq,
    input logic [LVL_W-1:0] fifo_level
);

    // R8: a set flag holds while the clear input is low.
    a_r8_hold_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !err_clear) |=> parity_err);
    a_r8_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clear) |=> frame_err);
    a_r8_hold_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !err_clear) |=> overrun_err);

    // R8: a held clear empties all three flags.
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> (!parity_err && !frame_err && !overrun_err));

    // R10: the empty flag agrees with the FIFO level.
    a_r10_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty == (fifo_level == '0));

    // R9: the level never exceeds the depth.
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R11: the interrupt needs the enable and a non-empty FIFO.
    a_r11_irq_cond: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_enable && !rx_empty));

    // R12: a flush leaves the FIFO empty.
    a_r12_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_empty);

    // R12: with reception disabled the level cannot grow.
    a_r12_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (fifo_level <= $past(fifo_level)));

endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .rx_flush    (rx_flush),
    .err_clear   (err_clear),
    .irq_enable  (irq_enable),
    .rx_empty    (rx_empty),
    .parity_err  (parity_err),
    .frame_err   (frame_err),
    .overrun_err (overrun_err),
    .irq         (irq),
    .fifo_level  (fifo_level)
);

// File: tb/uart_rx_sticky_bench.sv
// Bench for uart_rx_sticky. A driver task serialises frames and queues the
// bytes it expects the FIFO to hold. A monitor pops the FIFO and compares
// each byte against the queue. Flags are checked directly after each frame.
module uart_rx_sticky_bench;

    localparam int TDIV    = 2;
    localparam int BIT_CYC = 16 * TDIV;
    localparam int DEPTH   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rx_enable = 1'b1;
    logic       rx_flush = 1'b0;
    logic       err_clear = 1'b0;
    logic [1:0] data_len = 2'd0;
    logic       parity_on = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [7:0] irq_level = 8'd1;
    logic       irq_enable = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty;
    logic       parity_err;
    logic       frame_err;
    logic       overrun_err;
    logic       irq;

    int checks = 0;
    int fails = 0;
    logic mon_on = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_rx_sticky u_uart_rx_sticky (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick_16x(tick_16x),
        .rx_enable(rx_enable), .rx_flush(rx_flush), .err_clear(err_clear),
        .data_len(data_len), .parity_on(parity_on), .parity_odd(parity_odd),
        .two_stop(two_stop), .irq_level(irq_level), .irq_enable(irq_enable),
        .rd_en(rd_en), .rd_data(rd_data), .rx_empty(rx_empty),
        .parity_err(parity_err), .frame_err(frame_err),
        .overrun_err(overrun_err), .irq(irq)
    );

    // Oversampling strobe generator, updated away from the active edge.
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt     = (tcnt + 1) % TDIV;
        tick_16x = (tcnt == 0);
    end

    task automatic chk(input logic ok, input string tag,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // Serialise one frame; queue the expected byte when 'expect_store' is set.
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic stop1, input logic stop2,
                              input logic expect_store);
        int nb;
        logic [7:0] m;
        logic p;
        nb = 8 - int'(data_len);
        m  = d & 8'((1 << nb) - 1);
        if (expect_store) exp_q.push_back(m);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (parity_on) begin
            p = (^m) ^ parity_odd ^ bad_par;
            drive_bit(p);
        end
        drive_bit(stop1);
        if (two_stop) drive_bit(stop2);
        drive_bit(1'b1);
    endtask

    task automatic clear_errors();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops each byte the FIFO presents and compares it with the queue.
    always @(negedge clk) begin
        if (mon_on && !rx_empty) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected byte", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R2/R3 byte", int'(rd_data), int'(e));
            end
            rd_en = 1'b1;
        end else begin
            rd_en = 1'b0;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_empty == 1'b1, "R1 empty", int'(rx_empty), 1);
        chk({parity_err, frame_err, overrun_err} == 3'b000, "R1 flags",
            int'({parity_err, frame_err, overrun_err}), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        repeat (BIT_CYC) @(negedge clk);

        // R2 8N1 frames in order
        mon_on = 1'b1;
        send_frame(8'hA5, 0, 1, 1, 1);
        send_frame(8'h3C, 0, 1, 1, 1);
        send_frame(8'h01, 0, 1, 1, 1);
        chk(exp_q.size() == 0, "R2 all received", exp_q.size(), 0);
        chk(frame_err == 1'b0, "R5 no frame error on good stop", int'(frame_err), 0);

        // R3 data lengths
        data_len = 2'd3; send_frame(8'h15, 0, 1, 1, 1);
        data_len = 2'd1; send_frame(8'hFF, 0, 1, 1, 1);
        data_len = 2'd2; send_frame(8'hEA, 0, 1, 1, 1);
        data_len = 2'd0;
        chk(exp_q.size() == 0, "R3 all received", exp_q.size(), 0);

        // R4 parity: good even, good odd, then a bad odd
        parity_on = 1'b1;
        send_frame(8'h07, 0, 1, 1, 1);
        parity_odd = 1'b1;
        send_frame(8'h07, 0, 1, 1, 1);
        chk(parity_err == 1'b0, "R4 good parity", int'(parity_err), 0);
        send_frame(8'h5A, 1, 1, 1, 1);
        chk(parity_err == 1'b1, "R4 bad parity flagged", int'(parity_err), 1);
        chk(frame_err == 1'b0, "R4 no frame error", int'(frame_err), 0);
        // R8 sticky after a good frame
        send_frame(8'h11, 0, 1, 1, 1);
        chk(parity_err == 1'b1, "R8 parity sticky", int'(parity_err), 1);
        clear_errors();
        chk(parity_err == 1'b0, "R8 parity cleared", int'(parity_err), 0);
        parity_on = 1'b0; parity_odd = 1'b0;

        // R5 bad single stop, then a bad second stop
        send_frame(8'h66, 0, 0, 1, 1);
        chk(frame_err == 1'b1, "R5 stop 0 flagged", int'(frame_err), 1);
        clear_errors();
        two_stop = 1'b1;
        send_frame(8'h99, 0, 1, 1, 1);
        chk(frame_err == 1'b0, "R5 two good stops", int'(frame_err), 0);
        send_frame(8'h99, 0, 1, 0, 1);
        chk(frame_err == 1'b1, "R5 second stop 0 flagged", int'(frame_err), 1);
        clear_errors();
        chk(frame_err == 1'b0, "R8 frame cleared", int'(frame_err), 0);
        two_stop = 1'b0;

        // R6 break: one zero byte with frame error
        exp_q.push_back(8'h00);
        rx_line = 1'b0;
        repeat (20 * BIT_CYC) @(negedge clk);
        chk(frame_err == 1'b1, "R6 break frame error", int'(frame_err), 1);
        chk(exp_q.size() == 0, "R6 zero byte seen", exp_q.size(), 0);
        chk(rx_empty == 1'b1, "R6 only one byte", int'(rx_empty), 1);
        rx_line = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        clear_errors();

        // R7 short low pulse is discarded
        rx_line = 1'b0;
        repeat (4 * TDIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        chk(rx_empty == 1'b1, "R7 glitch ignored", int'(rx_empty), 1);
        chk(frame_err == 1'b0, "R7 no error", int'(frame_err), 0);

        // R10/R11 threshold interrupt, monitor off
        mon_on = 1'b0;
        @(negedge clk);
        irq_level = 8'd3; irq_enable = 1'b1;
        send_frame(8'h21, 0, 1, 1, 0);
        chk(rx_empty == 1'b0, "R10 not empty", int'(rx_empty), 0);
        chk(rd_data == 8'h21, "R10 head byte", int'(rd_data), 8'h21);
        send_frame(8'h22, 0, 1, 1, 0);
        chk(irq == 1'b0, "R11 below level", int'(irq), 0);
        send_frame(8'h23, 0, 1, 1, 0);
        chk(irq == 1'b1, "R11 at level", int'(irq), 1);
        irq_enable = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R11 gated", int'(irq), 0);

        // R12 flush and disable
        rx_flush = 1'b1;
        @(negedge clk);
        rx_flush = 1'b0;
        @(negedge clk);
        chk(rx_empty == 1'b1, "R12 flushed", int'(rx_empty), 1);
        rx_enable = 1'b0;
        send_frame(8'h44, 0, 1, 1, 0);
        chk(rx_empty == 1'b1, "R12 disabled", int'(rx_empty), 1);
        rx_enable = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        irq_level = 8'd1;

        // R9 overrun: 17 frames, the last one dropped
        for (int k = 0; k < DEPTH; k++) send_frame(8'(8'h40 + k), 0, 1, 1, 1);
        chk(overrun_err == 1'b0, "R9 full, no overrun", int'(overrun_err), 0);
        send_frame(8'hEE, 0, 1, 1, 0);
        chk(overrun_err == 1'b1, "R9 overrun flagged", int'(overrun_err), 1);
        mon_on = 1'b1;
        repeat (4 * DEPTH) @(negedge clk);
        chk(exp_q.size() == 0, "R9 stored bytes intact", exp_q.size(), 0);
        chk(rx_empty == 1'b1, "R10 drained", int'(rx_empty), 1);
        clear_errors();
        chk(overrun_err == 1'b0, "R8 overrun cleared", int'(overrun_err), 0);

        finish_run();
    end

endmodule